// File: doc/BRIEF.md
# Paired-Word Compare and Select Unit

This block treats each 64-bit operand as two 32-bit words, a high lane and a low lane. A compare operation tests both lanes for equality and condenses the outcome into a 4-bit code. That code is stored into one of eight fields of an internal 32-bit condition register. A select operation later reads one of those fields and builds a 64-bit result lane by lane. Each result word comes from operand A or from operand B, as the field's lane flags direct.

Work is issued with a valid strobe, an opcode, both operands and two field indices. The result and the valid flag come out one clock later. The condition register is visible at all times, so a select issued right after a compare already sees the freshly written field. Sequences such as "compare, then merge the lanes that matched" therefore run without stalls.

Top module: `pw_cmpsel`

## Requirements
- R1: While reset is asserted (active low), and immediately after it, the condition register, the result and the output valid are all zero.
- R2: The output valid is high in the cycle after a cycle where the input valid was high, and low otherwise.
- R3: On a compare (opcode 2'b01), code bit 3 is 1 exactly when the high words (bits 63:32) of A and B are equal. Code bit 2 is 1 exactly when the low words (bits 31:0) are equal.
- R4: Code bit 1 is the OR of bits 3 and 2, and code bit 0 is their AND.
- R5: A compare writes its code into field k of the condition register, where k is the destination index. Field k occupies bits 31-4k down to 28-4k, so field 0 is the top nibble and field 7 the bottom nibble. Every other field keeps its value.
- R6: After a compare, the result holds the 4-bit code in bits 3:0 and zero in bits 63:4.
- R7: On a select (opcode 2'b10), the result high word is A's high word when bit 3 of the source field is 1, and B's high word otherwise.
- R8: On a select, the result low word is A's low word when bit 2 of the source field is 1, and B's low word otherwise.
- R9: A select leaves the condition register unchanged.
- R10: Opcodes 2'b00 and 2'b11 change neither the result nor the condition register, though the output valid still follows R2.
- R11: A select issued in the cycle directly after a compare reads the field as that compare wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operation on the inputs |
| opcode | input | 2 | 01 compare, 10 select, others no operation |
| op_a | input | 64 | Operand A, high word in bits 63:32 |
| op_b | input | 64 | Operand B, high word in bits 63:32 |
| dst_field | input | 3 | Condition field written by a compare |
| src_field | input | 3 | Condition field read by a select |
| out_valid | output | 1 | Result valid, one cycle after issue |
| result | output | 64 | Select result, or the compare code zero-extended |
| cond_reg | output | 32 | Condition register, field 0 in the top nibble |

## Verification
The hardest case to reach from the ports is a select that depends on a compare issued in the cycle just before it. It only exercises the forwarding order if the two strobes are back to back with no idle cycle between them. The bench drives exactly that pair. It also writes fields where only one lane matched, in both directions. Those mixed codes show whether each result word is steered by its own code bit rather than by the OR or AND bits.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 2;
  localparam int CODE_W = LANES + 2;
  localparam int FIELDS = 8;
  localparam int FIDX_W = $clog2(FIELDS);
  localparam int DATA_W = WORD_W * LANES;
  localparam int CREG_W = CODE_W * FIELDS;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_CMP  = 2'b01,
    OP_SEL  = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  // lane flags on top (high lane first), then their OR, then their AND
  function automatic logic [CODE_W-1:0] pack_code(input logic [LANES-1:0] eq);
    return {eq, |eq, &eq};
  endfunction
endpackage

// File: rtl/pw_lane_eq.sv
module pw_lane_eq #(
  parameter int WORD_W = 32,
  parameter int LANES  = 2
) (
  input  logic [WORD_W*LANES-1:0] a,
  input  logic [WORD_W*LANES-1:0] b,
  output logic [LANES-1:0]        eq
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign eq[l] = (a[l*WORD_W +: WORD_W] == b[l*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/pw_cond_file.sv
module pw_cond_file #(
  parameter int CODE_W = 4,
  parameter int FIELDS = 8,
  localparam int FIDX_W = $clog2(FIELDS),
  localparam int CREG_W = CODE_W * FIELDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FIDX_W-1:0] wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [FIDX_W-1:0] rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [CREG_W-1:0] creg
);
  logic [CODE_W-1:0] fld_q [FIELDS];

  for (genvar f = 0; f < FIELDS; f++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fld_q[f] <= '0;
      else if (wr_en && wr_idx == FIDX_W'(f))
        fld_q[f] <= wr_code;
    end
    // field 0 lands in the most significant nibble
    assign creg[(FIELDS-1-f)*CODE_W +: CODE_W] = fld_q[f];
  end

  assign rd_code = fld_q[rd_idx];
endmodule

// File: rtl/pw_lane_sel.sv
module pw_lane_sel #(
  parameter int WORD_W = 32,
  parameter int LANES  = 2
) (
  input  logic [WORD_W*LANES-1:0] a,
  input  logic [WORD_W*LANES-1:0] b,
  input  logic [LANES-1:0]        pick_a,
  output logic [WORD_W*LANES-1:0] y
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign y[l*WORD_W +: WORD_W] = pick_a[l] ? a[l*WORD_W +: WORD_W]
                                             : b[l*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/pw_cmpsel.sv
module pw_cmpsel
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [FIDX_W-1:0] dst_field,
  input  logic [FIDX_W-1:0] src_field,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [CREG_W-1:0] cond_reg
);
  // named internal events
  logic              fire_cmp;
  logic              fire_sel;
  logic [LANES-1:0]  lane_eq;
  logic [CODE_W-1:0] cmp_code;
  logic [CODE_W-1:0] src_code;
  logic [LANES-1:0]  pick_a;
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  assign fire_cmp = in_valid && (op_e'(opcode) == OP_CMP);
  assign fire_sel = in_valid && (op_e'(opcode) == OP_SEL);

  pw_lane_eq #(.WORD_W(WORD_W), .LANES(LANES)) u_eq (
    .a (op_a),
    .b (op_b),
    .eq(lane_eq)
  );

  assign cmp_code = pack_code(lane_eq);

  pw_cond_file #(.CODE_W(CODE_W), .FIELDS(FIELDS)) u_cr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fire_cmp),
    .wr_idx (dst_field),
    .wr_code(cmp_code),
    .rd_idx (src_field),
    .rd_code(src_code),
    .creg   (cond_reg)
  );

  // lane flags sit in the top LANES bits of a code
  assign pick_a = src_code[CODE_W-1 -: LANES];

  pw_lane_sel #(.WORD_W(WORD_W), .LANES(LANES)) u_sel (
    .a     (op_a),
    .b     (op_b),
    .pick_a(pick_a),
    .y     (sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (fire_cmp)
        result_q <= DATA_W'(cmp_code);
      else if (fire_sel)
        result_q <= sel_word;
    end
  end

  assign result    = result_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/pw_cmpsel_chk.sv
module pw_cmpsel_chk
  import pw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        opcode,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [FIDX_W-1:0] dst_field,
  input logic [FIDX_W-1:0] src_field,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [CREG_W-1:0] cond_reg,
  input logic              fire_cmp,
  input logic              fire_sel
);
  function automatic logic [CODE_W-1:0] fld(input logic [CREG_W-1:0] cr,
                                            input logic [FIDX_W-1:0] i);
    return cr[(FIELDS-1-int'(i))*CODE_W +: CODE_W];
  endfunction

  function automatic logic [CREG_W-1:0] fmask(input logic [FIDX_W-1:0] i);
    logic [CREG_W-1:0] m;
    m = '0;
    m[(FIELDS-1-int'(i))*CODE_W +: CODE_W] = '1;
    return m;
  endfunction

  logic idle_op;
  assign idle_op = in_valid && (opcode == 2'b00 || opcode == 2'b11);

  p_valid_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_cmp |=> (fld(cond_reg, $past(dst_field))[3] ==
                  ($past(op_a[63:32]) == $past(op_b[63:32])))
              && (fld(cond_reg, $past(dst_field))[2] ==
                  ($past(op_a[31:0]) == $past(op_b[31:0]))));
  p_or_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_cmp |=> (fld(cond_reg, $past(dst_field))[1] ==
                  (fld(cond_reg, $past(dst_field))[3] | fld(cond_reg, $past(dst_field))[2]))
              && (fld(cond_reg, $past(dst_field))[0] ==
                  (fld(cond_reg, $past(dst_field))[3] & fld(cond_reg, $past(dst_field))[2])));
  p_others_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_cmp |=> ((cond_reg ^ $past(cond_reg)) & ~fmask($past(dst_field))) == '0);
  p_cmp_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_cmp |=> result == DATA_W'(fld(cond_reg, $past(dst_field))));
  p_sel_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_sel |=> result[63:32] == (fld($past(cond_reg), $past(src_field))[3]
                                   ? $past(op_a[63:32]) : $past(op_b[63:32])));
  p_sel_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_sel |=> result[31:0] == (fld($past(cond_reg), $past(src_field))[2]
                                  ? $past(op_a[31:0]) : $past(op_b[31:0])));
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_sel |=> $stable(cond_reg));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_op |=> $stable(result) && $stable(cond_reg));
endmodule

bind pw_cmpsel pw_cmpsel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opcode   (opcode),
  .op_a     (op_a),
  .op_b     (op_b),
  .dst_field(dst_field),
  .src_field(src_field),
  .out_valid(out_valid),
  .result   (result),
  .cond_reg (cond_reg),
  .fire_cmp (fire_cmp),
  .fire_sel (fire_sel)
);

// File: tb/sim_pw_cmpsel.sv
`timescale 1ns/1ps
module sim_pw_cmpsel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [2:0]  dst_field = '0;
  logic [2:0]  src_field = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] cond_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] cr_m = '0;
  logic [63:0] res_m = '0;

  always #10 clk = ~clk;

  pw_cmpsel u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .dst_field(dst_field), .src_field(src_field),
    .out_valid(out_valid), .result(result), .cond_reg(cond_reg)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent restatement of the code table
  function automatic logic [3:0] code_of(input logic [63:0] a, input logic [63:0] b);
    case ({a[63:32] == b[63:32], a[31:0] == b[31:0]})
      2'b11:   return 4'b1111;
      2'b10:   return 4'b1010;
      2'b01:   return 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] get_f(input logic [31:0] cr, input int k);
    return 4'((cr >> (28 - 4*k)) & 32'hF);
  endfunction

  function automatic logic [31:0] put_f(input logic [31:0] cr, input int k, input logic [3:0] c);
    logic [31:0] sh;
    sh = 32'hF << (28 - 4*k);
    return (cr & ~sh) | ({28'b0, c} << (28 - 4*k));
  endfunction

  task automatic drive(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                       input int dst, input int src);
    in_valid  = 1'b1;
    opcode    = op;
    op_a      = a;
    op_b      = b;
    dst_field = 3'(dst);
    src_field = 3'(src);
  endtask

  task automatic t_reset();
    chk("R1 cond_reg", {32'b0, cond_reg}, 64'h0);
    chk("R1 result", result, 64'h0);
    chk("R1 out_valid", {63'b0, out_valid}, 64'h0);
  endtask

  task automatic t_compare(input logic [63:0] a, input logic [63:0] b, input int dst);
    logic [3:0] c;
    @(negedge clk);
    drive(2'b01, a, b, dst, 0);
    @(negedge clk);
    in_valid = 1'b0;
    c = code_of(a, b);
    cr_m = put_f(cr_m, dst, c);
    res_m = {60'b0, c};
    chk("R3/R4/R5 cond_reg after compare", {32'b0, cond_reg}, {32'b0, cr_m});
    chk("R6 compare result", result, res_m);
    chk("R2 out_valid high", {63'b0, out_valid}, 64'h1);
    @(negedge clk);
    chk("R2 out_valid low", {63'b0, out_valid}, 64'h0);
  endtask

  task automatic t_select(input logic [63:0] a, input logic [63:0] b, input int src);
    logic [3:0] c;
    c = get_f(cr_m, src);
    @(negedge clk);
    drive(2'b10, a, b, 0, src);
    @(negedge clk);
    in_valid = 1'b0;
    res_m = {c[3] ? a[63:32] : b[63:32], c[2] ? a[31:0] : b[31:0]};
    chk("R7 select high word", {32'b0, result[63:32]}, {32'b0, res_m[63:32]});
    chk("R8 select low word", {32'b0, result[31:0]}, {32'b0, res_m[31:0]});
    chk("R9 select keeps cond_reg", {32'b0, cond_reg}, {32'b0, cr_m});
  endtask

  task automatic t_idle(input logic [1:0] op);
    @(negedge clk);
    drive(op, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111, 6, 7);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 no-op result", result, res_m);
    chk("R10 no-op cond_reg", {32'b0, cond_reg}, {32'b0, cr_m});
    chk("R2 no-op out_valid", {63'b0, out_valid}, 64'h1);
  endtask

  task automatic t_back_to_back();
    logic [63:0] a1, b1, a2, b2;
    logic [3:0] c;
    a1 = 64'h0000_00AA_1234_5678; b1 = 64'h0000_00AA_8765_4321; // high lane only
    a2 = 64'hDEAD_BEEF_0BAD_F00D; b2 = 64'hCAFE_F00D_FEED_FACE;
    @(negedge clk);
    drive(2'b01, a1, b1, 2, 0);
    @(negedge clk);
    drive(2'b10, a2, b2, 0, 2);
    c = code_of(a1, b1);
    cr_m = put_f(cr_m, 2, c);
    chk("R5 back-to-back compare field", {32'b0, cond_reg}, {32'b0, cr_m});
    @(negedge clk);
    in_valid = 1'b0;
    res_m = {c[3] ? a2[63:32] : b2[63:32], c[2] ? a2[31:0] : b2[31:0]};
    chk("R11 select sees fresh field", result, res_m);
    chk("R2 back-to-back valid", {63'b0, out_valid}, 64'h1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compare(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 0); // both equal
    t_compare(64'hAAAA_0000_0000_0001, 64'hAAAA_0000_0000_0002, 7); // high only
    t_compare(64'h0000_0001_5555_5555, 64'h8000_0001_5555_5555, 3); // low only
    t_compare(64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 5); // neither
    t_select(64'hA1A1_A1A1_A2A2_A2A2, 64'hB1B1_B1B1_B2B2_B2B2, 7);
    t_select(64'hA1A1_A1A1_A2A2_A2A2, 64'hB1B1_B1B1_B2B2_B2B2, 3);
    t_select(64'hA1A1_A1A1_A2A2_A2A2, 64'hB1B1_B1B1_B2B2_B2B2, 0);
    t_select(64'hA1A1_A1A1_A2A2_A2A2, 64'hB1B1_B1B1_B2B2_B2B2, 5);
    t_compare(64'h0000_0001_0000_0002, 64'h0000_0003_0000_0004, 0); // overwrite field 0
    t_select(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 0);
    t_idle(2'b00);
    t_idle(2'b11);
    t_back_to_back();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule